// File: doc/BRIEF.md
# Status-Code I2C Master Engine

This block is a byte-level I2C master. Software steers it through a control word that is changed only through two write strobes: one sets the bits written as 1, the other clears the bits written as 1. Software also writes one data byte at a time. The engine generates START, clocks out an address byte or a data byte, or clocks in a data byte. It then generates STOP when asked. After every bus event it raises the event flag, posts one fixed 8-bit status code and holds SCL low. It keeps SCL low until software clears the flag. Software therefore needs no timing of its own: it reads the code, loads the next byte or changes a control bit, and then clears the flag.

Both bus lines are open-drain. The engine drives an output enable that pulls a line low and reads the line back on a separate input. A bus monitor watches for START and STOP from any master. A new START is issued only while the bus is free. If the engine releases SDA for a 1 bit and reads the line back low, it has lost arbitration and withdraws from the bus.

The sequencer has these states. `S_IDLE` waits for STA. `S_STA_LO` pulls SDA low with SCL high. `S_STA_CLK` pulls SCL low. `S_HOLD` stretches SCL while the flag is set. `S_BIT_LO` is the low phase of SCL, where SDA is set up. `S_BIT_HI` is the high phase, where SDA is sampled and the engine waits for SCL to read high. `S_STP_LO`, `S_STP_CLK` and `S_STP_REL` produce STOP.

The transitions are: `S_IDLE`→`S_STA_LO` on STA with a free bus; `S_STA_LO`→`S_STA_CLK`→`S_HOLD`; `S_HOLD`→`S_BIT_LO` on a flag clear; `S_HOLD`→`S_STP_LO` on a flag clear with STO set; `S_HOLD`→`S_IDLE` on a flag clear after a lost arbitration; `S_BIT_LO`→`S_BIT_HI`; `S_BIT_HI`→`S_BIT_LO` for the next bit; `S_BIT_HI`→`S_HOLD` after the ninth bit or on a lost arbitration; and `S_STP_LO`→`S_STP_CLK`→`S_STP_REL`→`S_IDLE`. Clearing the enable bit forces `S_IDLE` from any state.

Top module: `i2c_stat_master`

## Requirements
- R1: After reset the control word reads 0x00, the status reads 0xF8, the data byte reads 0x00 and neither line is pulled low.
- R2: When enable (bit 6) and STA (bit 5) are set and the bus is free, the engine pulls SDA low while SCL is high (a START). It then sets the flag (bit 3) with status 0x08.
- R3: The first byte after START is shifted MSB first and is followed by a ninth clock for the acknowledge, where SDA low means ACK. Its low bit 0 selects write and 1 selects read. The status that follows is 0x18 (write, ACK), 0x20 (write, NACK), 0x40 (read, ACK) or 0x48 (read, NACK).
- R4: While the flag is set, and arbitration has not been lost, SCL is held low.
- R5: In transmit, each later data byte ends with status 0x28 on ACK or 0x30 on NACK.
- R6: In receive, the AA bit (bit 2) sets what the engine returns on the ninth clock: SDA low when AA is 1, released when AA is 0. The status is 0x50 or 0x58 respectively, and the received byte is placed in the data byte.
- R7: With STO (bit 4) set, clearing the flag produces a STOP (SDA rises while SCL is high). STO then clears itself, the status returns to 0xF8 and the flag stays clear.
- R8: A data-byte write is accepted only while the flag is set or the engine is idle. A write while a byte is on the bus leaves the data byte unchanged.
- R9: When a released SDA bit of an address or transmit byte reads back low, the engine sets the flag with status 0x38 and releases both lines. Clearing the flag then returns it to idle.
- R10: Set writes affect only bits 6, 5, 4 and 2. Clear writes affect bits 6 to 2. Bits 7, 1 and 0 read 0, writing 0 changes nothing, the flag cannot be set by software, and a set and a clear of the same bit in one cycle leave it set.
- R11: No START is issued while enable is 0, or while the bus is busy after a START from another master. A START is issued once a STOP frees the bus. With enable 0, both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_set_we | input | 1 | Strobe for the set write |
| ctl_set_data | input | 8 | Bits to set |
| ctl_clr_we | input | 1 | Strobe for the clear write |
| ctl_clr_data | input | 8 | Bits to clear |
| dat_we | input | 1 | Data byte write strobe |
| dat_wdata | input | 8 | Byte to transmit |
| ctl_q | output | 8 | Control word |
| stat_q | output | 8 | Status code |
| dat_q | output | 8 | Data byte (last written or last received) |
| scl_in | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low |

## Verification
Two writes to the control word can land in the same cycle: a set of a bit and a clear of that same bit. The bench raises both strobes on the AA bit in one cycle and then reads the control word back, expecting the bit to remain set. Hardware updates can also coincide with software writes. The bench covers the case where the engine's own STO clear at the end of STOP is judged from status and control after the sequence, and an assertion ties every hardware drop of STO to status 0xF8.

// File: rtl/i2c_sm_pkg.sv
package i2c_sm_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_STA_LO, S_STA_CLK, S_HOLD, S_BIT_LO, S_BIT_HI,
        S_STP_LO, S_STP_CLK, S_STP_REL
    } eng_state_t;

    localparam int B_EN  = 6;
    localparam int B_STA = 5;
    localparam int B_STO = 4;
    localparam int B_SI  = 3;
    localparam int B_AA  = 2;

    localparam logic [7:0] KEEP_MASK = 8'h7C;
    localparam logic [7:0] SET_MASK  = 8'h74;

    localparam logic [7:0] C_START = 8'h08;
    localparam logic [7:0] C_ARB   = 8'h38;
    localparam logic [7:0] C_NONE  = 8'hF8;

    function automatic logic [7:0] byte_code(input logic addr_ph, input logic rw,
                                             input logic rxm, input logic slv_ack,
                                             input logic own_ack);
        if (addr_ph)
            return rw ? (slv_ack ? 8'h40 : 8'h48) : (slv_ack ? 8'h18 : 8'h20);
        else if (rxm)
            return own_ack ? 8'h50 : 8'h58;
        else
            return slv_ack ? 8'h28 : 8'h30;
    endfunction
endpackage

// File: rtl/i2c_sm_sync.sv
module i2c_sm_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] ff;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= 2'b11;
            else        ff <= {ff[0], d[i]};
        end
        assign q[i] = ff[1];
    end
endmodule

// File: rtl/i2c_sm_busmon.sv
module i2c_sm_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic bus_free
);
    logic scl_d, sda_d, busy;
    logic seen_start, seen_stop;

    assign seen_start = sda_d & ~sda & scl & scl_d;
    assign seen_stop  = ~sda_d & sda & scl & scl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
            busy  <= 1'b0;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
            if (seen_start)     busy <= 1'b1;
            else if (seen_stop) busy <= 1'b0;
        end
    end

    assign bus_free = ~busy;
endmodule

// File: rtl/i2c_sm_timer.sv
module i2c_sm_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (restart)     cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);
endmodule

// File: rtl/i2c_sm_ctlreg.sv
module i2c_sm_ctlreg
    import i2c_sm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_we,
    input  logic [7:0] set_data,
    input  logic       clr_we,
    input  logic [7:0] clr_data,
    input  logic       hw_si_set,
    input  logic       hw_sto_clr,
    output logic [7:0] ctl
);
    logic [7:0] nxt;

    always_comb begin
        nxt = ctl & ~(clr_we ? clr_data : 8'h00);
        if (hw_sto_clr) nxt[B_STO] = 1'b0;
        nxt = nxt | (set_we ? (set_data & SET_MASK) : 8'h00);
        if (hw_si_set) nxt[B_SI] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl <= 8'h00;
        else        ctl <= nxt & KEEP_MASK;
    end
endmodule

// File: rtl/i2c_stat_master.sv
module i2c_stat_master
    import i2c_sm_pkg::*;
#(
    parameter int HALF_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_set_we,
    input  logic [7:0] ctl_set_data,
    input  logic       ctl_clr_we,
    input  logic [7:0] ctl_clr_data,
    input  logic       dat_we,
    input  logic [7:0] dat_wdata,
    output logic [7:0] ctl_q,
    output logic [7:0] stat_q,
    output logic [7:0] dat_q,
    input  logic       scl_in,
    output logic       scl_oe,
    input  logic       sda_in,
    output logic       sda_oe
);
    localparam logic [3:0] LAST_BIT = 4'd8;

    eng_state_t st, nxt;
    logic [1:0] line_s;
    logic       scl_s, sda_s, bus_free, done;
    logic       en, sta, sto, si, aa;
    logic       sda_drv, first_byte, rx_mode, lost;
    logic [3:0] bit_cnt;
    logic [7:0] shreg, dat_reg, stat;
    logic       bit_last, tx_bit, sample, arb_lost, hw_si_set, hw_sto_clr;

    i2c_sm_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c_sm_busmon u_mon (
        .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s), .bus_free(bus_free)
    );

    i2c_sm_timer #(.LIMIT(HALF_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .restart(nxt != st), .done(done)
    );

    i2c_sm_ctlreg u_ctl (
        .clk(clk), .rst_n(rst_n),
        .set_we(ctl_set_we), .set_data(ctl_set_data),
        .clr_we(ctl_clr_we), .clr_data(ctl_clr_data),
        .hw_si_set(hw_si_set), .hw_sto_clr(hw_sto_clr), .ctl(ctl_q)
    );

    assign en  = ctl_q[B_EN];
    assign sta = ctl_q[B_STA];
    assign sto = ctl_q[B_STO];
    assign si  = ctl_q[B_SI];
    assign aa  = ctl_q[B_AA];

    assign bit_last = (bit_cnt == LAST_BIT);
    assign tx_bit   = first_byte | ~rx_mode;
    assign sample   = (st == S_BIT_HI) & done & scl_s;
    assign arb_lost = (st == S_BIT_HI) & ~bit_last & tx_bit & ~sda_drv & ~sda_s;
    assign hw_si_set  = en & (((st == S_STA_CLK) & done) | (sample & (bit_last | arb_lost)));
    assign hw_sto_clr = en & (st == S_STP_REL) & done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // transitions
    always_comb begin
        nxt = st;
        if (!en) begin
            nxt = S_IDLE;
        end else begin
            unique case (st)
                S_IDLE:    if (sta && !si && bus_free) nxt = S_STA_LO;
                S_STA_LO:  if (done) nxt = S_STA_CLK;
                S_STA_CLK: if (done) nxt = S_HOLD;
                S_HOLD:    if (!si) nxt = lost ? S_IDLE : (sto ? S_STP_LO : S_BIT_LO);
                S_BIT_LO:  if (done) nxt = S_BIT_HI;
                S_BIT_HI:  if (sample) nxt = (bit_last || arb_lost) ? S_HOLD : S_BIT_LO;
                S_STP_LO:  if (done) nxt = S_STP_CLK;
                S_STP_CLK: if (done && scl_s) nxt = S_STP_REL;
                S_STP_REL: if (done) nxt = S_IDLE;
                default:   nxt = S_IDLE;
            endcase
        end
    end

    // byte datapath and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_drv    <= 1'b0;
            shreg      <= 8'h00;
            bit_cnt    <= 4'd0;
            first_byte <= 1'b0;
            rx_mode    <= 1'b0;
            lost       <= 1'b0;
            stat       <= C_NONE;
            dat_reg    <= 8'h00;
        end else begin
            if (dat_we && (si || st == S_IDLE)) dat_reg <= dat_wdata;
            if (!en) begin
                sda_drv <= 1'b0;
                lost    <= 1'b0;
                stat    <= C_NONE;
            end else begin
                unique case (st)
                    S_IDLE: sda_drv <= (nxt == S_STA_LO);
                    S_STA_CLK: if (done) begin
                        stat       <= C_START;
                        first_byte <= 1'b1;
                        rx_mode    <= 1'b0;
                        lost       <= 1'b0;
                    end
                    S_HOLD: if (!si) begin
                        if (lost) begin
                            stat <= C_NONE;
                            lost <= 1'b0;
                        end else if (sto) begin
                            sda_drv <= 1'b1;
                        end else begin
                            shreg   <= dat_reg;
                            bit_cnt <= 4'd0;
                        end
                    end
                    S_BIT_LO: sda_drv <= bit_last ? (~tx_bit & aa) : (tx_bit & ~shreg[7]);
                    S_BIT_HI: if (sample) begin
                        if (arb_lost) begin
                            stat    <= C_ARB;
                            lost    <= 1'b1;
                            sda_drv <= 1'b0;
                        end else if (!bit_last) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else begin
                            stat <= byte_code(first_byte, shreg[0], rx_mode, ~sda_s, aa);
                            if (first_byte) begin
                                rx_mode    <= shreg[0];
                                first_byte <= 1'b0;
                            end else if (rx_mode) begin
                                dat_reg <= shreg;
                            end
                        end
                    end
                    S_STP_CLK: if (done && scl_s) sda_drv <= 1'b0;
                    S_STP_REL: if (done) stat <= C_NONE;
                    default: ;
                endcase
            end
        end
    end

    // line outputs
    always_comb begin
        scl_oe = 1'b0;
        unique case (st)
            S_STA_CLK, S_BIT_LO, S_STP_LO: scl_oe = 1'b1;
            S_HOLD:                         scl_oe = ~lost;
            default:                        scl_oe = 1'b0;
        endcase
        sda_oe = sda_drv & (st != S_IDLE);
    end

    assign stat_q = stat;
    assign dat_q  = dat_reg;
endmodule

// File: rtl/i2c_stat_master_chk.sv
module i2c_stat_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_clr_we,
    input logic [7:0] ctl_clr_data,
    input logic [7:0] ctl_q,
    input logic [7:0] stat_q,
    input logic       scl_oe,
    input logic       sda_oe
);
    assert_flag_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q[3]) |-> (stat_q != 8'hF8));

    assert_scl_stretch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[3] && ctl_q[6] && stat_q != 8'h38) |-> scl_oe);

    assert_sto_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctl_q[4]) && !$past(ctl_clr_we && ctl_clr_data[4])) |-> (stat_q == 8'hF8));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[3] && !(ctl_clr_we && ctl_clr_data[3])) |=> ctl_q[3]);

    assert_off_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[6] |=> (!scl_oe && !sda_oe));
endmodule

bind i2c_stat_master i2c_stat_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_clr_we(ctl_clr_we), .ctl_clr_data(ctl_clr_data),
    .ctl_q(ctl_q), .stat_q(stat_q), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_stat_master_bench.sv
module i2c_stat_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_set_we = 1'b0, ctl_clr_we = 1'b0, dat_we = 1'b0;
    logic [7:0] ctl_set_data = 8'h00, ctl_clr_data = 8'h00, dat_wdata = 8'h00;
    logic [7:0] ctl_q, stat_q, dat_q;
    logic       scl_oe, sda_oe;
    logic       ext_sda_low = 1'b0, s_sda_low = 1'b0;
    logic       scl_line, sda_line;
    int         n_chk = 0, n_fail = 0, cyc = 0;
    int         start_cnt = 0, stop_cnt = 0;

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | s_sda_low | ext_sda_low);

    always #2.5 clk = ~clk;

    i2c_stat_master u_i2c_stat_master (
        .clk(clk), .rst_n(rst_n),
        .ctl_set_we(ctl_set_we), .ctl_set_data(ctl_set_data),
        .ctl_clr_we(ctl_clr_we), .ctl_clr_data(ctl_clr_data),
        .dat_we(dat_we), .dat_wdata(dat_wdata),
        .ctl_q(ctl_q), .stat_q(stat_q), .dat_q(dat_q),
        .scl_in(scl_line), .scl_oe(scl_oe), .sda_in(sda_line), .sda_oe(sda_oe)
    );

    // slave model at address 0x5A
    logic       s_active = 1'b0, s_after = 1'b0, s_addr_ph = 1'b0;
    logic       s_match = 1'b0, s_reading = 1'b0, s_mack = 1'b0;
    logic [7:0] s_rx = 8'h00, s_last_wr = 8'h00;
    int         s_cnt = 0, s_txidx = 0;

    always @(negedge sda_line) if (scl_line) begin
        start_cnt++; s_active = 1'b1; s_after = 1'b1; s_cnt = 0; s_addr_ph = 1'b1;
        s_match = 1'b0; s_reading = 1'b0; s_txidx = 0; s_sda_low = 1'b0;
    end
    always @(posedge sda_line) if (scl_line) begin
        stop_cnt++; s_active = 1'b0; s_sda_low = 1'b0;
    end
    always @(posedge scl_line) if (s_active) begin
        if (s_cnt < 8) s_rx = {s_rx[6:0], sda_line};
        else           s_mack = ~sda_line;
    end
    always @(negedge scl_line) if (s_active) begin
        logic [7:0] txb;
        if (s_after) s_after = 1'b0;
        else begin
            s_cnt++;
            if (s_cnt == 9) begin
                s_cnt = 0;
                if (s_addr_ph) begin
                    s_addr_ph = 1'b0;
                    s_reading = s_match & s_rx[0];
                end else if (s_reading) begin
                    s_txidx++;
                    if (!s_mack) s_reading = 1'b0;
                end
            end
        end
        txb = s_txidx[0] ? 8'h3C : 8'hC3;
        s_sda_low = 1'b0;
        if (s_cnt == 8) begin
            if (s_addr_ph) begin
                s_match = (s_rx[7:1] == 7'h5A);
                s_sda_low = s_match;
            end else if (s_match && !s_reading) begin
                s_last_wr = s_rx;
                s_sda_low = (s_rx != 8'hFF);
            end
        end else if (s_reading) begin
            s_sda_low = ~txb[7 - s_cnt];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_set(input logic [7:0] v);
        @(negedge clk); ctl_set_we = 1'b1; ctl_set_data = v;
        @(negedge clk); ctl_set_we = 1'b0;
    endtask
    task automatic wr_clr(input logic [7:0] v);
        @(negedge clk); ctl_clr_we = 1'b1; ctl_clr_data = v;
        @(negedge clk); ctl_clr_we = 1'b0;
    endtask
    task automatic wr_dat(input logic [7:0] v);
        @(negedge clk); dat_we = 1'b1; dat_wdata = v;
        @(negedge clk); dat_we = 1'b0;
    endtask
    task automatic wait_si();
        while (!ctl_q[3]) @(negedge clk);
    endtask

    function automatic string tag_of(input logic [7:0] code);
        case (code)
            8'h08:                      return "R2";
            8'h18, 8'h20, 8'h40, 8'h48: return "R3";
            8'h28, 8'h30:               return "R5";
            8'h50, 8'h58:               return "R6";
            8'hF8:                      return "R7";
            default:                    return "R9";
        endcase
    endfunction

    // {op, aa, wdata, expected status, expected data}; op 0 start, 1 send, 2 receive, 3 stop
    localparam logic [26:0] VEC [0:15] = '{
        {2'd0, 1'b0, 8'h00, 8'h08, 8'h00},
        {2'd1, 1'b0, 8'hB4, 8'h18, 8'hB4},
        {2'd1, 1'b0, 8'h12, 8'h28, 8'h12},
        {2'd1, 1'b0, 8'hFF, 8'h30, 8'hFF},
        {2'd3, 1'b0, 8'h00, 8'hF8, 8'h00},
        {2'd0, 1'b0, 8'h00, 8'h08, 8'h00},
        {2'd1, 1'b0, 8'h66, 8'h20, 8'h66},
        {2'd3, 1'b0, 8'h00, 8'hF8, 8'h00},
        {2'd0, 1'b0, 8'h00, 8'h08, 8'h00},
        {2'd1, 1'b0, 8'hB5, 8'h40, 8'hB5},
        {2'd2, 1'b1, 8'h00, 8'h50, 8'hC3},
        {2'd2, 1'b0, 8'h00, 8'h58, 8'h3C},
        {2'd3, 1'b0, 8'h00, 8'hF8, 8'h00},
        {2'd0, 1'b0, 8'h00, 8'h08, 8'h00},
        {2'd1, 1'b0, 8'h67, 8'h48, 8'h67},
        {2'd3, 1'b0, 8'h00, 8'hF8, 8'h00}
    };

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        int s0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ctl", ctl_q, 8'h00);
        chk("R1 stat", stat_q, 8'hF8);
        chk("R1 dat", dat_q, 8'h00);
        chk("R1 lines", {scl_oe, sda_oe}, 2'b00);

        // R10: masking, zero writes, same-cycle set and clear
        wr_set(8'h8F);
        chk("R10 set mask", ctl_q, 8'h04);
        wr_clr(8'h00);
        chk("R10 clear zero", ctl_q, 8'h04);
        @(negedge clk);
        ctl_set_we = 1'b1; ctl_set_data = 8'h04; ctl_clr_we = 1'b1; ctl_clr_data = 8'h04;
        @(negedge clk);
        ctl_set_we = 1'b0; ctl_clr_we = 1'b0;
        chk("R10 set wins", ctl_q, 8'h04);
        wr_clr(8'h04);
        chk("R10 clear", ctl_q, 8'h00);

        // R11: disabled engine never starts
        s0 = start_cnt;
        wr_set(8'h20);
        repeat (40) @(negedge clk);
        chk("R11 disabled flag", ctl_q[3], 1'b0);
        chk("R11 disabled bus", start_cnt, s0);
        wr_clr(8'h20);
        wr_set(8'h40);

        for (int i = 0; i < 16; i++) begin
            logic [1:0] op;
            logic       aa;
            logic [7:0] wd, es, ed;
            {op, aa, wd, es, ed} = VEC[i];
            if (op == 2'd0) begin
                s0 = start_cnt;
                wr_set(8'h20);
                wait_si();
                wr_clr(8'h20);
                chk("R2 start seen", start_cnt, s0 + 1);
                chk(tag_of(es), stat_q, {24'h0, es});
                chk("R4 scl held", scl_oe, 1'b1);
            end else if (op == 2'd3) begin
                s0 = stop_cnt;
                wr_set(8'h10);
                wr_clr(8'h08);
                while (ctl_q[4]) @(negedge clk);
                @(negedge clk);
                chk("R7 stop seen", stop_cnt, s0 + 1);
                chk(tag_of(es), stat_q, {24'h0, es});
                chk("R7 flag clear", ctl_q[3], 1'b0);
                chk("R7 lines high", {scl_line, sda_line}, 2'b11);
            end else begin
                if (op == 2'd1) wr_dat(wd);
                if (aa) wr_set(8'h04); else wr_clr(8'h04);
                wr_clr(8'h08);
                repeat (20) @(negedge clk);
                wr_dat(8'h99);
                wait_si();
                chk(tag_of(es), stat_q, {24'h0, es});
                chk(op == 2'd2 ? "R6 data" : "R8 data", dat_q, {24'h0, ed});
                chk("R4 scl held", scl_oe, 1'b1);
                if (es == 8'h28 || es == 8'h30)
                    chk("R5 slave byte", s_last_wr, {24'h0, wd});
            end
        end

        // R9: arbitration lost on first address bit
        wr_set(8'h20);
        wait_si();
        wr_clr(8'h20);
        wr_dat(8'hB4);
        ext_sda_low = 1'b1;
        wr_clr(8'h08);
        wait_si();
        chk("R9 status", stat_q, 8'h38);
        chk("R9 released", {scl_oe, sda_oe}, 2'b00);

        // R11: busy bus blocks a new START until a STOP
        s0 = start_cnt;
        wr_set(8'h20);
        wr_clr(8'h08);
        repeat (60) @(negedge clk);
        chk("R9 back idle", stat_q, 8'hF8);
        chk("R11 busy bus", start_cnt, s0);
        chk("R11 busy lines", sda_oe, 1'b0);
        ext_sda_low = 1'b0;
        wait_si();
        wr_clr(8'h20);
        chk("R11 start after free", stat_q, 8'h08);
        wr_set(8'h10);
        wr_clr(8'h08);
        while (ctl_q[4]) @(negedge clk);
        @(negedge clk);
        chk("R7 final idle", stat_q, 8'hF8);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule